// File: doc/BRIEF.md
# Interrupt Target Context

This block is one target context of a platform-level interrupt controller. It sees the pending bit and the priority of every interrupt source as input vectors. It keeps its own priority threshold, a per-source enable mask and a per-source claimed flag. From these it decides whether its target should be interrupted, and it drives a single registered interrupt line.

The target uses a small register bus with an address, write data, read data and separate read and write strobes.

- A read of the claim register returns the identifier of the best eligible source and marks that source claimed in the same cycle.
- Writing an identifier to the same register completes that source and releases it.
- Source identifier 0 is reserved and means "no interrupt".

Register addresses are: threshold 0, claim/complete 1, enable mask 2. Address 3 reads as zero and ignores writes. Read data is combinational and is zero when no read strobe is present. If read and write strobes are both high, the write takes effect and the claim side effect of the read is suppressed.

Top module: `irq_target_ctx`

## Requirements
- R1: A write to the threshold register (address 0) keeps only the low PRIO_W bits of the write data; that masked value is what a later read of address 0 returns.
- R2: The threshold resets to 0. A masked threshold value greater than MAX_PRIO is dropped and leaves the stored threshold unchanged.
- R3: A source is eligible only when its ID is nonzero, it is pending, its enable bit is set, its claimed flag is clear, and its priority is strictly greater than the threshold.
- R4: A read of address 1 returns, in bits [ID_W-1:0], the ID of the eligible source with the highest priority. Ties go to the lower ID. The read returns 0 when no source is eligible.
- R5: A claim read that returns a nonzero ID sets that source's claimed flag at the same clock edge.
- R6: A write to address 1 whose value is a nonzero ID below N_SRC, naming an enabled source, clears that source's claimed flag.
- R7: A completion write naming a source whose enable bit is clear is ignored, and its claimed flag stays set.
- R8: A completion write of 0, or of any value not below N_SRC, has no effect on any claimed flag.
- R9: The interrupt output is 0 out of reset. After each clock edge it equals whether any source was eligible just before that edge, so it follows changes one cycle later.
- R10: A write to address 2 loads the enable mask from write data bits [N_SRC-1:0], with bit 0 always held at 0. A read of address 2 returns the mask, and the mask resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| src_pending | input | N_SRC | Pending bit per source, bit 0 unused |
| src_prio | input | N_SRC*PRIO_W | Priority per source, source i at [i*PRIO_W +: PRIO_W] |
| irq_out | output | 1 | Registered interrupt line to the target |

## Verification
The bench builds the block with N_SRC = 12, PRIO_W = 3 and MAX_PRIO = 5.

- Twelve sources give a 4-bit ID field with IDs 12 to 15 unused. Completion writes of those IDs show that out-of-range values are rejected, and do not alias onto a valid flag.
- With a maximum priority of 5 in a 3-bit field, threshold writes of 6 and 7 fit the field but must be dropped. Writes with high bits set show the masking.
- Priorities up to 5 allow ties at equal priority, a source sitting exactly at the threshold, and sources above it.

// File: rtl/irq_ctx_pkg.sv
// Package: shared register selector for the interrupt target context.
// Assumes a two-bit register address space.
package irq_ctx_pkg;

    typedef enum logic [1:0] {
        SEL_THRESH = 2'd0,
        SEL_CLAIM  = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Turns a raw address into a register selector.
    function automatic reg_sel_e decode_sel(input logic [1:0] addr);
        return reg_sel_e'(addr);
    endfunction

endpackage

// File: rtl/ctx_threshold_reg.sv
// Threshold register. Masks write data to the priority field width and
// stores the result only if it does not exceed MAX_PRIO.
// Assumes MAX_PRIO < 2**PRIO_W.
module ctx_threshold_reg #(
    parameter int PRIO_W   = 3,
    parameter int MAX_PRIO = 5,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [PRIO_W-1:0] thr
);
    localparam logic [PRIO_W-1:0] MAXP = PRIO_W'(MAX_PRIO);

    logic [PRIO_W-1:0] masked;
    logic              accept;

    // Keep only the priority field and test it against the ceiling.
    always_comb begin
        masked = wdata[PRIO_W-1:0];
        accept = wr_en && (masked <= MAXP);
    end

    // Hold the threshold; load accepted values.
    always_ff @(posedge clk) begin
        if (!rst_n)      thr <= '0;
        else if (accept) thr <= masked;
    end

    AST_THR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        thr <= MAXP); // R2
    AST_THR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wdata[PRIO_W-1:0] > MAXP)) |=> (thr == $past(thr))); // R2

endmodule

// File: rtl/ctx_claim_flags.sv
// Per-source claimed flags. A claim sets one flag; a completion clears one
// flag if the ID is in range, nonzero and enabled. Bit 0 is always 0.
// Assumes N_SRC <= DATA_W.
module ctx_claim_flags #(
    parameter int N_SRC  = 16,
    parameter int DATA_W = 32,
    parameter int ID_W   = $clog2(N_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim_fire,
    input  logic [ID_W-1:0]   claim_id,
    input  logic              done_wr,
    input  logic [DATA_W-1:0] done_word,
    input  logic [N_SRC-1:0]  en_mask,
    output logic [N_SRC-1:0]  claimed
);
    logic            in_range;
    logic [ID_W-1:0] done_id;
    logic            done_ok;

    // Qualify the completion: nonzero, below N_SRC and enabled here.
    always_comb begin
        in_range = (done_word != '0) && (done_word < DATA_W'(N_SRC));
        done_id  = done_word[ID_W-1:0];
        done_ok  = done_wr && in_range && en_mask[done_id];
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_flag
        if (i == 0) begin : g_zero
            assign claimed[i] = 1'b0;
        end else begin : g_bit
            // Set on claim, clear on accepted completion, else hold.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    claimed[i] <= 1'b0;
                else if (claim_fire && (claim_id == ID_W'(i)))
                    claimed[i] <= 1'b1;
                else if (done_ok && (done_id == ID_W'(i)))
                    claimed[i] <= 1'b0;
            end
        end
    end

    AST_DONE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_wr && in_range && !en_mask[done_id] && claimed[done_id])
        |=> claimed[$past(done_id)]); // R7
    AST_DONE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_wr && !in_range && !claim_fire) |=> (claimed == $past(claimed))); // R8

endmodule

// File: rtl/ctx_arbiter.sv
// Eligibility and best-source selection. A source is eligible when it is
// pending, enabled, unclaimed and strictly above the threshold. The highest
// priority wins; ties go to the lower ID. Purely combinational.
module ctx_arbiter #(
    parameter int N_SRC  = 16,
    parameter int PRIO_W = 3,
    parameter int ID_W   = $clog2(N_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          pending,
    input  logic [N_SRC-1:0]          en_mask,
    input  logic [N_SRC-1:0]          claimed,
    input  logic [N_SRC*PRIO_W-1:0]   prio_flat,
    input  logic [PRIO_W-1:0]         thr,
    output logic [N_SRC-1:0]          elig,
    output logic [ID_W-1:0]           best_id,
    output logic                      any_elig
);
    logic [PRIO_W-1:0] best_p;

    for (genvar i = 0; i < N_SRC; i++) begin : g_elig
        if (i == 0) begin : g_zero
            assign elig[i] = 1'b0;
        end else begin : g_src
            assign elig[i] = pending[i] && en_mask[i] && !claimed[i]
                             && (prio_flat[i*PRIO_W +: PRIO_W] > thr);
        end
    end

    // Scan IDs upward; strict compare keeps the lower ID on ties.
    always_comb begin
        best_id = '0;
        best_p  = '0;
        for (int i = 1; i < N_SRC; i++) begin
            if (elig[i] && ((best_id == '0) ||
                (prio_flat[i*PRIO_W +: PRIO_W] > best_p))) begin
                best_id = ID_W'(i);
                best_p  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
        any_elig = (best_id != '0);
    end

    AST_ID_ELIG: assert property (@(posedge clk) disable iff (!rst_n)
        (best_id != '0) |-> elig[best_id]); // R4
    AST_ID_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (best_id == '0) |-> (elig == '0)); // R4

endmodule

// File: rtl/irq_target_ctx.sv
// Top of one interrupt target context: register decode, enable mask,
// threshold, claimed flags, arbitration and the registered interrupt line.
// Assumes 2 <= N_SRC <= DATA_W; source ID 0 is reserved.
module irq_target_ctx #(
    parameter int N_SRC    = 16,
    parameter int PRIO_W   = 3,
    parameter int MAX_PRIO = 5,
    parameter int DATA_W   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               bus_addr,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    input  logic [N_SRC-1:0]         src_pending,
    input  logic [N_SRC*PRIO_W-1:0]  src_prio,
    output logic                     irq_out
);
    import irq_ctx_pkg::*;

    localparam int ID_W = $clog2(N_SRC);

    reg_sel_e          sel;
    logic              thr_wr, en_wr, done_wr, claim_fire;
    logic [PRIO_W-1:0] thr;
    logic [N_SRC-1:0]  en_q, claimed, elig;
    logic [ID_W-1:0]   best_id;
    logic              any_elig;

    // Decode strobes; a write in the same cycle suppresses the claim.
    always_comb begin
        sel        = decode_sel(bus_addr);
        thr_wr     = bus_wr && (sel == SEL_THRESH);
        en_wr      = bus_wr && (sel == SEL_ENABLE);
        done_wr    = bus_wr && (sel == SEL_CLAIM);
        claim_fire = bus_rd && !bus_wr && (sel == SEL_CLAIM) && (best_id != '0);
    end

    // Enable mask register; source 0 can never be enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= {bus_wdata[N_SRC-1:1], 1'b0};
    end

    // Registered interrupt line: one-cycle view of eligibility.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= any_elig;
    end

    // Read mux; zero when no read strobe.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_THRESH: bus_rdata = DATA_W'(thr);
                SEL_CLAIM:  bus_rdata = DATA_W'(best_id);
                SEL_ENABLE: bus_rdata = DATA_W'(en_q);
                default:    bus_rdata = '0;
            endcase
        end
    end

    ctx_threshold_reg #(.PRIO_W(PRIO_W), .MAX_PRIO(MAX_PRIO), .DATA_W(DATA_W)) u_thr (
        .clk(clk), .rst_n(rst_n), .wr_en(thr_wr), .wdata(bus_wdata), .thr(thr)
    );

    ctx_claim_flags #(.N_SRC(N_SRC), .DATA_W(DATA_W), .ID_W(ID_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .claim_fire(claim_fire), .claim_id(best_id),
        .done_wr(done_wr), .done_word(bus_wdata), .en_mask(en_q), .claimed(claimed)
    );

    ctx_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .pending(src_pending), .en_mask(en_q),
        .claimed(claimed), .prio_flat(src_prio), .thr(thr), .elig(elig),
        .best_id(best_id), .any_elig(any_elig)
    );

    AST_CLAIM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire |=> claimed[$past(best_id)]); // R5
    AST_EN_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (en_q[0] == 1'b0)); // R10

endmodule

// File: tb/irq_target_ctx_bench.sv
// Bench for irq_target_ctx. A behavioural reference model (integer arrays)
// is stepped at each rising edge and compared against the ports on every
// falling edge. Directed checks add fixed expected values.
module irq_target_ctx_bench;
    localparam int N  = 12;
    localparam int PW = 3;
    localparam int MP = 5;
    localparam int DW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      bus_addr = '0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [N-1:0]    src_pending = '0;
    logic [N*PW-1:0] src_prio = '0;
    logic            irq_out;

    int    n_run = 0, n_fail = 0, cycles = 0;
    string phase = "R9";
    logic [DW-1:0] got;

    // reference model state
    int m_thr;
    int m_irq;
    bit m_en[N];
    bit m_cl[N];

    always #2.5 clk = ~clk;

    irq_target_ctx #(.N_SRC(N), .PRIO_W(PW), .MAX_PRIO(MP), .DATA_W(DW)) u_irq_target_ctx (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_pending(src_pending), .src_prio(src_prio), .irq_out(irq_out)
    );

    function automatic int prio_of(int i);
        return int'(src_prio[i*PW +: PW]);
    endfunction

    // Best eligible ID under the current model state, 0 if none.
    function automatic int model_best();
        int b = 0, bp = -1;
        for (int i = 1; i < N; i++) begin
            if (src_pending[i] && m_en[i] && !m_cl[i] && prio_of(i) > m_thr
                && prio_of(i) > bp) begin
                b  = i;
                bp = prio_of(i);
            end
        end
        return b;
    endfunction

    function automatic int model_rdata();
        int v = 0;
        if (!bus_rd) return 0;
        case (bus_addr)
            2'd0: v = m_thr;
            2'd1: v = model_best();
            2'd2: for (int i = 0; i < N; i++) v += (m_en[i] ? (1 << i) : 0);
            default: v = 0;
        endcase
        return v;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Step the model at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_thr = 0;
            m_irq = 0;
            for (int i = 0; i < N; i++) begin m_en[i] = 0; m_cl[i] = 0; end
        end else begin
            int b;
            int w;
            b = model_best();
            m_irq = (b != 0);
            w = int'(bus_wdata);
            if (bus_rd && !bus_wr && bus_addr == 2'd1 && b != 0) m_cl[b] = 1;
            if (bus_wr) begin
                case (bus_addr)
                    2'd0: if ((w % (1 << PW)) <= MP) m_thr = w % (1 << PW);
                    2'd1: if (bus_wdata > 0 && bus_wdata < N && m_en[w]) m_cl[w] = 0;
                    2'd2: for (int i = 1; i < N; i++) m_en[i] = bus_wdata[i];
                    default: ;
                endcase
            end
        end
    end

    // Compare ports to the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check({phase, " irq"}, irq_out, m_irq);
            check({phase, " rdata"}, bus_rdata, model_rdata());
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // One bus cycle; the read data is captured before the edge.
    task automatic op(bit rd, bit wr, logic [1:0] a, logic [DW-1:0] d);
        @(posedge clk);
        #1;
        bus_rd = rd;
        bus_wr = wr;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        #0.5;
        got = bus_rdata;
        @(posedge clk);
        #1;
        bus_rd = 0;
        bus_wr = 0;
    endtask

    task automatic rd_expect(string tag, logic [1:0] a, int exp);
        op(1, 0, a, '0);
        check(tag, got, exp);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) op(0, 0, 2'd3, '0);
    endtask

    initial begin
        int pr[N];
        pr = '{0, 1, 1, 4, 1, 2, 1, 4, 1, 5, 1, 3};
        for (int i = 0; i < N; i++) src_prio[i*PW +: PW] = PW'(pr[i]);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        phase = "R9";
        check("R9 reset irq", irq_out, 0);
        rd_expect("R2 reset threshold", 2'd0, 0);
        rd_expect("R10 reset enable", 2'd2, 0);
        rd_expect("R4 empty claim", 2'd1, 0);

        phase = "R1";
        op(0, 1, 2'd0, 32'd3);
        rd_expect("R1 thr 3", 2'd0, 3);
        op(0, 1, 2'd0, 32'hFC);
        rd_expect("R1 thr masked", 2'd0, 4);
        phase = "R2";
        op(0, 1, 2'd0, 32'd6);
        rd_expect("R2 drop 6", 2'd0, 4);
        op(0, 1, 2'd0, 32'h1F);
        rd_expect("R2 drop 7", 2'd0, 4);
        op(0, 1, 2'd0, 32'd0);

        phase = "R10";
        src_pending = '1;
        op(0, 1, 2'd2, 32'hFFFF);
        rd_expect("R10 enable bit0", 2'd2, 32'hFFE);
        idle(2);
        check("R9 irq up", irq_out, 1);

        phase = "R4";
        rd_expect("R4 top prio", 2'd1, 9);
        rd_expect("R4 tie low ID", 2'd1, 3);
        rd_expect("R5 next after claim", 2'd1, 7);
        phase = "R6";
        op(0, 1, 2'd1, 32'd3);
        rd_expect("R6 reclaim", 2'd1, 3);

        phase = "R3";
        op(0, 1, 2'd0, 32'd4);
        rd_expect("R3 none above thr", 2'd1, 0);
        idle(2);
        check("R9 irq low", irq_out, 0);
        op(0, 1, 2'd1, 32'd9);
        idle(1);
        check("R9 irq after done", irq_out, 1);
        rd_expect("R6 9 back", 2'd1, 9);
        op(0, 1, 2'd0, 32'd5);
        op(0, 1, 2'd1, 32'd9);
        rd_expect("R3 equal to thr", 2'd1, 0);
        op(0, 1, 2'd0, 32'd0);

        phase = "R7";
        rd_expect("R7 claim 9", 2'd1, 9);
        op(0, 1, 2'd2, 32'hFFE & ~32'h200);
        op(0, 1, 2'd1, 32'd9);
        op(0, 1, 2'd2, 32'hFFE);
        rd_expect("R7 9 stays claimed", 2'd1, 11);

        phase = "R8";
        op(0, 1, 2'd1, 32'd0);
        op(0, 1, 2'd1, 32'd12);
        op(0, 1, 2'd1, 32'd15);
        op(0, 1, 2'd1, 32'h103);
        rd_expect("R8 no release", 2'd1, 5);
        rd_expect("R8 low prio", 2'd1, 1);

        phase = "R3";
        src_pending = '0;
        op(0, 1, 2'd1, 32'd3);
        rd_expect("R3 not pending", 2'd1, 0);
        src_pending = '1;
        op(0, 1, 2'd2, 32'h010);
        rd_expect("R3 only enabled", 2'd1, 4);
        idle(2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule